// File: doc/BRIEF.md
# Zone-Selected Decimal Index Adder

This block turns a five-character decimal address into an effective address. Each character is six bits: a 2-bit zone above a 4-bit BCD digit. The zones over the hundreds and tens digits together name one of fifteen index registers. Zero means no indexing. The index registers are five-character fields kept in main memory at fixed, computed locations.

When an index is named, the block reads the register through a memory read port. It reads one character per cycle, lowest-order digit first. While the characters arrive, it adds them to the address digit by digit in BCD, with a carry from one digit to the next. A carry out of the ten-thousands digit is dropped, so the sum wraps modulo 100000 and a large register value acts as a subtraction.

The result appears with every zone bit cleared. It is marked by a one-cycle done pulse. The address unit of a character-oriented processor uses the block once per address it forms.

Top module: `zone_index_adder`

## Requirements
- R1: Character k of `addr_in` sits in bits [6k+5:6k], with k=0 the units digit. Bits [6k+3:6k] hold the digit and bits [6k+5:6k+4] hold the zone. The index number is {hundreds zone (bits 17:16), tens zone (bits 11:10)}, so the hundreds zone supplies the two high bits.
- R2: With index number 0, no memory read is issued. `done` rises in the cycle after the start cycle, and `ea_out` carries the address digits unchanged.
- R3: With index number n (1..15), the register occupies addresses 20+5n to 24+5n, and the units character is at the highest address. Reads are issued on five consecutive cycles at 24+5n, 23+5n, ... 20+5n. The first read is issued combinationally in the start cycle.
- R4: Read data is taken from `mem_rdata` in the cycle after the corresponding `mem_rd_en`.
- R5: Each register character contributes only its low four bits; its zone is ignored. Digits are summed in BCD with the carry passed upward.
- R6: A carry out of the ten-thousands digit is discarded, so the result is (address + register) mod 100000.
- R7: Every zone bit of `ea_out` is 0 when `done` is high, whatever zones the address carried.
- R8: For an indexed address, `busy` is high from the cycle after start until the result is ready. `done` is a single-cycle pulse, six cycles after the start cycle.
- R9: `start` is ignored while `busy` is high. The result in progress and the read addresses are unaffected, and no extra `done` appears.
- R10: A `start` in the cycle where `done` is high is accepted and begins a new resolution.
- R11: `ea_out` holds its value while the block is idle and no start is given, even if `addr_in` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin resolving `addr_in` (taken when not busy) |
| addr_in | input | 30 | Five zoned decimal characters, units at the low end |
| mem_rd_en | output | 1 | Memory read request |
| mem_addr | output | AW (17) | Binary memory address of the character requested |
| mem_rdata | input | 6 | Character returned one cycle after the request |
| busy | output | 1 | Indexed resolution in progress |
| done | output | 1 | One-cycle pulse: `ea_out` is valid |
| ea_out | output | 30 | Effective address, zone bits cleared |

## Verification
The result of one resolution and the acceptance of the next can fall in the same cycle. `done` of the first request and `start` of the second are both high there. The bench waits for `done` and raises `start` on that very cycle, once with an unindexed follow-up and once with an indexed one. A scoreboard then checks that each result appears with the right value at its own predicted cycle, and that the reads for the second request begin in that shared cycle.

// File: rtl/zone_index_adder.sv
module zone_index_adder #(
  parameter int AW     = 17,
  parameter int BASE   = 20,
  parameter int STRIDE = 5,
  parameter int ND     = 5,
  parameter int CW     = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [ND*CW-1:0] addr_in,
  output logic             mem_rd_en,
  output logic [AW-1:0]    mem_addr,
  input  logic [CW-1:0]    mem_rdata,
  output logic             busy,
  output logic             done,
  output logic [ND*CW-1:0] ea_out
);
  localparam int XW = ND * CW;
  localparam int KW = $clog2(ND);
  localparam logic [KW-1:0] LAST = KW'(ND - 1);

  function automatic logic [XW-1:0] strip(input logic [XW-1:0] v);
    logic [XW-1:0] r;
    r = v;
    for (int k = 0; k < ND; k++) r[k*CW+4 +: CW-4] = '0;
    return r;
  endfunction

  logic [3:0]    idx_in, idx_q, sel_idx;
  logic [KW-1:0] cnt, rd_k;
  logic          carry, accept, go_idx;
  logic [XW-1:0] ea_q;
  logic [3:0]    cur_d, dsum;
  logic [4:0]    raw;
  logic          nc;

  assign idx_in  = {addr_in[2*CW+4 +: 2], addr_in[CW+4 +: 2]};
  assign accept  = start & ~busy;
  assign go_idx  = accept & (idx_in != 4'd0);
  assign sel_idx = accept ? idx_in : idx_q;
  assign rd_k    = accept ? '0 : KW'(cnt + 1'b1);

  assign mem_rd_en = go_idx | (busy & (cnt != LAST));
  assign mem_addr  = AW'(BASE + STRIDE * int'(sel_idx) + ND - 1 - int'(rd_k));

  assign cur_d = ea_q[int'(cnt)*CW +: 4];
  assign raw   = 5'(cur_d) + 5'(mem_rdata[3:0]) + 5'(carry);
  assign nc    = raw > 5'd9;
  assign dsum  = nc ? 4'(raw - 5'd10) : raw[3:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      cnt   <= '0;
      idx_q <= '0;
      carry <= 1'b0;
      ea_q  <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        ea_q  <= strip(addr_in);
        idx_q <= idx_in;
        cnt   <= '0;
        carry <= 1'b0;
        busy  <= idx_in != 4'd0;
        done  <= idx_in == 4'd0;
      end else if (busy) begin
        ea_q[int'(cnt)*CW +: 4] <= dsum;
        carry <= nc;
        if (cnt == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt <= KW'(cnt + 1'b1);
        end
      end
    end
  end

  assign ea_out = ea_q;
endmodule

// File: rtl/zone_index_adder_sva.sv
module zone_index_adder_sva #(
  parameter int AW     = 17,
  parameter int BASE   = 20,
  parameter int STRIDE = 5,
  parameter int ND     = 5,
  parameter int CW     = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [ND*CW-1:0] addr_in,
  input logic             mem_rd_en,
  input logic [AW-1:0]    mem_addr,
  input logic             busy,
  input logic             done,
  input logic [ND*CW-1:0] ea_out
);
  logic [ND*CW-1:0] zmask;
  always_comb begin
    zmask = '0;
    for (int k = 0; k < ND; k++) zmask[k*CW+4 +: CW-4] = '1;
  end

  p_no_read_idx0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && addr_in[2*CW+4 +: 2] == 2'b00 && addr_in[CW+4 +: 2] == 2'b00) |-> !mem_rd_en);

  p_rd_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> (int'(mem_addr) >= BASE + STRIDE && int'(mem_addr) <= BASE + STRIDE * 16 - 1));

  p_zone_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((ea_out & zmask) == '0));

  p_busy_ends_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !done);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(ea_out));
endmodule

bind zone_index_adder zone_index_adder_sva #(
  .AW(AW), .BASE(BASE), .STRIDE(STRIDE), .ND(ND), .CW(CW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .addr_in(addr_in),
  .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .busy(busy),
  .done(done), .ea_out(ea_out)
);

// File: tb/zone_index_adder_tb_top.sv
module zone_index_adder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [29:0] addr_in = '0;
  logic        mem_rd_en, busy, done;
  logic [16:0] mem_addr;
  logic [5:0]  mem_rdata = '0;
  logic [29:0] ea_out;

  zone_index_adder dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .addr_in(addr_in),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .ea_out(ea_out)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [5:0] mem [0:127];
  int rv [0:15];
  always @(posedge clk) if (mem_rd_en) mem_rdata <= mem[mem_addr[6:0]];

  int checks = 0, errors = 0;
  typedef struct { logic [29:0] ea; int due; string tag; } exp_t;
  exp_t q[$];
  exp_t x;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic [29:0] enc(input int v);
    logic [29:0] r = '0;
    int t = v;
    for (int k = 0; k < 5; k++) begin
      r[k*6 +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  function automatic int dval(input logic [29:0] a);
    int r = 0;
    for (int k = 4; k >= 0; k--) r = r * 10 + int'(a[k*6 +: 4]);
    return r;
  endfunction

  function automatic logic [29:0] mk(input int val, input int idx, input logic [1:0] jz);
    logic [29:0] r = enc(val);
    for (int k = 0; k < 5; k++) r[k*6+4 +: 2] = jz;
    r[17:16] = 2'(idx >> 2);
    r[11:10] = 2'(idx);
    return r;
  endfunction

  function automatic int regval(input int n);
    int r = 0;
    for (int k = 4; k >= 0; k--) r = r * 10 + int'(mem[20 + 5*n + 4 - k][3:0]);
    return r;
  endfunction

  task automatic setreg(input int n, input int v, input logic [1:0] z);
    logic [29:0] e = enc(v);
    for (int k = 0; k < 5; k++) mem[20 + 5*n + 4 - k] = {z, e[k*6 +: 4]};
  endtask

  // R1 R4: the expected value uses the index formed from the two zones and the one-cycle read data
  task automatic go(input logic [29:0] a, input string tag);
    int idx = int'({a[17:16], a[11:10]});
    int e = (idx == 0) ? dval(a) : (dval(a) + regval(idx)) % 100000;
    start = 1'b1;
    addr_in = a;
    q.push_back('{enc(e), cyc + ((idx == 0) ? 1 : 6), tag});
    #1;
    if (idx == 0) chk(!mem_rd_en, "R2", "read on unindexed", 64'(mem_rd_en), 0);
    else chk(mem_rd_en && int'(mem_addr) == 24 + 5*idx, "R3", "first read addr",
             64'(mem_addr), 64'(24 + 5*idx));
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy || q.size() != 0) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        if (q.size() == 0) chk(0, "R8", "unexpected done", 1, 0);
        else begin
          x = q.pop_front();
          chk(cyc == x.due, x.tag, "done cycle", 64'(cyc), 64'(x.due));
          chk(ea_out == x.ea, x.tag, "ea", 64'(ea_out), 64'(x.ea));
        end
      end else if (q.size() != 0 && cyc > q[0].due) begin
        x = q.pop_front();
        chk(0, x.tag, "done missing", 64'(cyc), 64'(x.due));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "WATCHDOG", "run hung", 64'(cyc), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [29:0] held;
    for (int i = 0; i < 128; i++) mem[i] = 6'h00;
    rv[1] = 7;      rv[2] = 12345; rv[3] = 999;   rv[4] = 400;
    rv[5] = 60000;  rv[6] = 31415; rv[7] = 27182; rv[8] = 50;
    for (int n = 9; n <= 14; n++) rv[n] = (n * 7919) % 100000;
    rv[15] = 99999;
    for (int n = 1; n <= 15; n++) setreg(n, rv[n], (n == 2) ? 2'b10 : 2'b00);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !mem_rd_en, "R8", "reset flags", {busy, done, mem_rd_en}, 0);
    chk(ea_out == '0, "R11", "reset ea", 64'(ea_out), 0);

    // R2 R7: unindexed with stray zones everywhere else
    go(mk(12345, 0, 2'b11), "R2");
    wait_idle();

    // R3 R5: traced read order for register 1
    go(mk(100, 1, 2'b00), "R3");
    for (int k = 1; k < 5; k++) begin
      chk(mem_rd_en && int'(mem_addr) == 29 - k, "R3", "read sequence", 64'(mem_addr), 64'(29 - k));
      chk(busy, "R8", "busy during reads", 64'(busy), 1);
      @(negedge clk);
    end
    chk(!mem_rd_en && busy && !done, "R8", "last add cycle", {mem_rd_en, busy, done}, 3'b010);
    wait_idle();

    go(mk(1, 3, 2'b00), "R5");          // carry chain 00001+00999
    wait_idle();
    go(mk(11111, 2, 2'b00), "R5");      // register chars carry zones
    wait_idle();
    go(mk(50000, 15, 2'b01), "R6");     // wraps to 49999
    wait_idle();
    go(mk(70000, 5, 2'b00), "R6");      // wraps to 30000
    wait_idle();
    go(mk(0, 8, 2'b00), "R1");          // hundreds zone high bits
    wait_idle();
    go(mk(0, 4, 2'b00), "R1");
    wait_idle();

    // R9: start while busy is ignored
    go(mk(222, 6, 2'b00), "R9");
    start = 1'b1;
    addr_in = mk(33333, 0, 2'b00);
    @(negedge clk);
    addr_in = mk(44444, 9, 2'b00);
    @(negedge clk);
    start = 1'b0;
    wait_idle();

    // R10: starts in the done cycle
    go(mk(5, 7, 2'b00), "R10");
    while (!done) @(negedge clk);
    go(mk(98765, 0, 2'b00), "R10");
    while (!done) @(negedge clk);
    go(mk(98765, 12, 2'b10), "R10");
    wait_idle();

    // R11: output held while idle
    held = ea_out;
    for (int k = 0; k < 4; k++) begin
      addr_in = mk(k * 1111, k, 2'b11);
      @(negedge clk);
      chk(ea_out == held, "R11", "idle hold", 64'(ea_out), 64'(held));
    end

    for (int n = 1; n <= 15; n++) begin
      go(mk(99999, n, 2'b00), "R6");
      wait_idle();
    end

    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R8", "scoreboard drained", 64'(q.size()), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule